// File: doc/BRIEF.md
# Dual-Output PWM Duty Generator

This block is one PWM generator that drives a high-side and a low-side raw pulse signal. It has two ways to get its count. In shared mode it takes one of two master counts, adds a phase offset and compares the result with one duty value. The low output is then the complement of the high output. In local mode each output has its own counter and its own duty and period values. The inputs that act as phase in shared mode act as periods in local mode.

In local mode a counter can run in edge-aligned form, rising and then wrapping. It can also run in center-aligned form, rising to the period and falling back to zero. A current-limit input can clear the high-side counter. Duty and phase/period values either take effect on the next clock or wait in a shadow stage until the next cycle boundary. A strobe output marks that boundary. Dead-time insertion, fault handling and pin override are left to downstream blocks.

Top module: `pwm_dual_gen`

## Requirements
- R1: With `itb_mode`=0 (shared mode), `pwm_h` is 1 exactly when ((selected master count + active high phase) mod 65536) < active high duty. `pwm_l` is the inverse of `pwm_h`, and `duty_l`/`phase_l` have no effect.
- R2: `mtb_sel`=0 selects `prim_count` as the master count and `mtb_sel`=1 selects `sec_count`.
- R3: A duty value of 0 keeps its output at 0. A duty value above the period keeps a local-mode output at 1 for the whole cycle.
- R4: With `itb_mode`=1 and `cam_en`=0, each counter steps 0,1,..,P and then returns to 0, where P is the active period. That gives P+1 clocks per cycle. The high output compares its counter with `duty_h` and uses `phase_h` as its period. The low output uses `duty_l` and `phase_l`.
- R5: With `itb_mode`=1 and `cam_en`=1, each counter rises from 0 to P and falls back to 0, giving 2P clocks per cycle.
- R6: With `itb_mode`=0, `cam_en` has no effect, and both local counters are held at 0.
- R7: With `itb_mode`=1 and `xres_en`=1, `clim_in`=1 clears the high-side counter on the next clock. The low-side counter is not affected. With `xres_en`=0, `clim_in` has no effect.
- R8: With `iue`=1, the duty and phase/period inputs become active one clock after they are applied. With `iue`=0, each channel keeps its active values until the clock edge at its cycle boundary.
- R9: `cyc_strobe` marks the high channel's cycle boundary. In shared mode it is 1 when the selected master count is 0. In local edge-aligned mode it is 1 when the high counter is at or above its period. In local center-aligned mode it is 1 when the high counter is 0.
- R10: After synchronous reset, all active values and both counters are 0. The high-side counter starts counting upward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| prim_count | input | 16 | Primary master count |
| sec_count | input | 16 | Secondary master count |
| mtb_sel | input | 1 | Master select: 0 primary, 1 secondary |
| itb_mode | input | 1 | 0 shared master count, 1 local counters |
| cam_en | input | 1 | Center-aligned counting (local mode only) |
| iue | input | 1 | Immediate update of duty and phase/period |
| xres_en | input | 1 | Allow current-limit clear of high counter |
| clim_in | input | 1 | Current-limit input |
| duty_h | input | 16 | High duty (shared by both outputs in shared mode) |
| duty_l | input | 16 | Low duty (local mode) |
| phase_h | input | 16 | Phase offset (shared) or high period (local) |
| phase_l | input | 16 | Low period (local mode) |
| pwm_h | output | 1 | Raw high-side PWM |
| pwm_l | output | 1 | Raw low-side PWM |
| cyc_strobe | output | 1 | High channel cycle boundary |

## Verification
The outputs are combinational from the active registers, the local counters and the master count. In shared mode, a result therefore shows up in the same cycle as a count change but one clock after a duty or phase change made with `iue`=1. A local counter moves one step per clock. The bench drives each input on a falling edge and samples 1 ns later, after k rising edges, where it expects the k-th counter value. A current-limit clear driven in sample k is expected to show as a zero count at sample k+1. A shadowed duty change is checked as still old up to the boundary sample and new in the sample after it.

// File: rtl/pwm_dual_pkg.sv
package pwm_dual_pkg;

    localparam int CNT_W  = 16;
    localparam int NUM_CH = 2;
    localparam int CH_HI  = 0;
    localparam int CH_LO  = 1;

    typedef logic [CNT_W-1:0] cnt_t;

    typedef enum logic {
        TB_SHARED = 1'b0,
        TB_LOCAL  = 1'b1
    } tb_mode_e;

    typedef enum logic {
        DIR_UP   = 1'b0,
        DIR_DOWN = 1'b1
    } dir_e;

    // duty and span (phase offset in shared mode, period in local mode)
    typedef struct packed {
        cnt_t duty;
        cnt_t span;
    } chan_set_t;

    function automatic logic duty_on(cnt_t c, cnt_t d);
        return c < d;
    endfunction

    function automatic cnt_t shift_count(cnt_t m, cnt_t ph);
        return m + ph;
    endfunction

endpackage

// File: rtl/pwm_shadow_reg.sv
module pwm_shadow_reg
    import pwm_dual_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      load,
    input  chan_set_t nxt,
    output chan_set_t act
);

    always_ff @(posedge clk) begin
        if (rst) begin
            act <= '0;
        end else if (load) begin
            act <= nxt;
        end
    end

endmodule

// File: rtl/pwm_local_timer.sv
module pwm_local_timer
    import pwm_dual_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic run,
    input  logic center,
    input  logic clr,
    input  cnt_t span,
    output cnt_t cnt,
    output logic wrap
);

    dir_e dir;

    always_comb begin
        wrap = center ? (cnt == '0) : (cnt >= span);
    end

    always_ff @(posedge clk) begin
        if (rst || !run || clr) begin
            cnt <= '0;
            dir <= DIR_UP;
        end else if (center) begin
            if (dir == DIR_UP) begin
                if (cnt >= span) begin
                    if (cnt != '0) begin
                        cnt <= cnt - 1'b1;
                        dir <= DIR_DOWN;
                    end
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end else begin
                if (cnt <= cnt_t'(1)) begin
                    cnt <= '0;
                    dir <= DIR_UP;
                end else begin
                    cnt <= cnt - 1'b1;
                end
            end
        end else begin
            dir <= DIR_UP;
            if (cnt >= span) begin
                cnt <= '0;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end

endmodule

// File: rtl/pwm_dual_gen.sv
module pwm_dual_gen
    import pwm_dual_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [CNT_W-1:0] prim_count,
    input  logic [CNT_W-1:0] sec_count,
    input  logic             mtb_sel,
    input  logic             itb_mode,
    input  logic             cam_en,
    input  logic             iue,
    input  logic             xres_en,
    input  logic             clim_in,
    input  logic [CNT_W-1:0] duty_h,
    input  logic [CNT_W-1:0] duty_l,
    input  logic [CNT_W-1:0] phase_h,
    input  logic [CNT_W-1:0] phase_l,
    output logic             pwm_h,
    output logic             pwm_l,
    output logic             cyc_strobe
);

    tb_mode_e          tb_mode;
    cnt_t              master_cnt;
    cnt_t              shifted_cnt;
    logic              master_zero;
    logic              center_run;
    logic              shared_on;

    chan_set_t         set_in [NUM_CH];
    chan_set_t         act_v  [NUM_CH];
    cnt_t              cnt_v  [NUM_CH];
    logic [NUM_CH-1:0] wrap_v;
    logic [NUM_CH-1:0] clr_v;

    cnt_t              cnt_hi;
    cnt_t              per_hi_act;
    cnt_t              duty_hi_act;

    assign tb_mode     = itb_mode ? TB_LOCAL : TB_SHARED;
    assign master_cnt  = mtb_sel ? sec_count : prim_count;
    assign master_zero = (master_cnt == '0);
    // center-aligned counting only applies with local counters
    assign center_run  = cam_en && (tb_mode == TB_LOCAL);

    assign set_in[CH_HI] = '{duty: duty_h, span: phase_h};
    assign set_in[CH_LO] = '{duty: duty_l, span: phase_l};

    // only the high-side counter answers the current-limit clear
    assign clr_v[CH_HI] = xres_en && (tb_mode == TB_LOCAL) && clim_in;
    assign clr_v[CH_LO] = 1'b0;

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        logic load;

        assign load = iue || ((tb_mode == TB_LOCAL) ? wrap_v[i] : master_zero);

        pwm_shadow_reg u_shadow (
            .clk  (clk),
            .rst  (rst),
            .load (load),
            .nxt  (set_in[i]),
            .act  (act_v[i])
        );

        pwm_local_timer u_timer (
            .clk    (clk),
            .rst    (rst),
            .run    (tb_mode == TB_LOCAL),
            .center (center_run),
            .clr    (clr_v[i]),
            .span   (act_v[i].span),
            .cnt    (cnt_v[i]),
            .wrap   (wrap_v[i])
        );
    end

    assign shifted_cnt = shift_count(master_cnt, act_v[CH_HI].span);
    assign shared_on   = duty_on(shifted_cnt, act_v[CH_HI].duty);

    always_comb begin
        if (tb_mode == TB_LOCAL) begin
            pwm_h      = duty_on(cnt_v[CH_HI], act_v[CH_HI].duty);
            pwm_l      = duty_on(cnt_v[CH_LO], act_v[CH_LO].duty);
            cyc_strobe = wrap_v[CH_HI];
        end else begin
            pwm_h      = shared_on;
            pwm_l      = !shared_on;
            cyc_strobe = master_zero;
        end
    end

    assign cnt_hi      = cnt_v[CH_HI];
    assign per_hi_act  = act_v[CH_HI].span;
    assign duty_hi_act = act_v[CH_HI].duty;

endmodule

// File: rtl/pwm_dual_chk.sv
module pwm_dual_chk
    import pwm_dual_pkg::*;
(
    input logic clk,
    input logic rst,
    input logic itb_mode,
    input logic cam_en,
    input logic iue,
    input logic xres_en,
    input logic clim_in,
    input logic pwm_h,
    input logic cyc_strobe,
    input cnt_t cnt_hi,
    input cnt_t per_hi_act,
    input cnt_t duty_hi_act
);

    a_r4_edge_step: assert property (@(posedge clk) disable iff (rst)
        (itb_mode && !cam_en && !(xres_en && clim_in) && cnt_hi < per_hi_act)
        |=> cnt_hi == cnt_t'($past(cnt_hi) + 1'b1));

    a_r4_edge_wrap: assert property (@(posedge clk) disable iff (rst)
        (itb_mode && !cam_en && cnt_hi >= per_hi_act) |=> cnt_hi == '0);

    a_r6_master_hold: assert property (@(posedge clk) disable iff (rst)
        !itb_mode |=> cnt_hi == '0);

    a_r7_clim_clear: assert property (@(posedge clk) disable iff (rst)
        (itb_mode && xres_en && clim_in) |=> cnt_hi == '0);

    a_r8_shadow_hold: assert property (@(posedge clk) disable iff (rst)
        (!iue && !cyc_strobe) |=> $stable(duty_hi_act));

    a_r3_zero_duty: assert property (@(posedge clk) disable iff (rst)
        (duty_hi_act == '0) |-> !pwm_h);

endmodule

bind pwm_dual_gen pwm_dual_chk u_chk (.*);

// File: tb/pwm_dual_gen_tb.sv
`timescale 1ns/1ps
module pwm_dual_gen_tb;

    logic        clk = 1'b0;
    logic        rst;
    logic [15:0] prim_count, sec_count;
    logic        mtb_sel, itb_mode, cam_en, iue, xres_en, clim_in;
    logic [15:0] duty_h, duty_l, phase_h, phase_l;
    logic        pwm_h, pwm_l, cyc_strobe;

    int n_vec = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    pwm_dual_gen u_dut (
        .clk(clk), .rst(rst), .prim_count(prim_count), .sec_count(sec_count),
        .mtb_sel(mtb_sel), .itb_mode(itb_mode), .cam_en(cam_en), .iue(iue),
        .xres_en(xres_en), .clim_in(clim_in), .duty_h(duty_h), .duty_l(duty_l),
        .phase_h(phase_h), .phase_l(phase_l), .pwm_h(pwm_h), .pwm_l(pwm_l),
        .cyc_strobe(cyc_strobe)
    );

    typedef struct packed {
        logic        sel;
        logic [15:0] pc;
        logic [15:0] sc;
        logic [15:0] duty;
        logic [15:0] ph;
        logic        eh;
        logic        el;
    } vec_t;

    // shared-mode vectors, iue=1 (R1, R2, R3)
    localparam vec_t VECS [8] = '{
        '{1'b0, 16'd10,     16'd0,  16'd20,     16'd0,     1'b1, 1'b0},
        '{1'b0, 16'd30,     16'd0,  16'd20,     16'd0,     1'b0, 1'b1},
        '{1'b0, 16'd10,     16'd0,  16'd20,     16'd15,    1'b0, 1'b1},
        '{1'b1, 16'd10,     16'd5,  16'd20,     16'd0,     1'b1, 1'b0},
        '{1'b1, 16'd5,      16'd50, 16'd20,     16'd0,     1'b0, 1'b1},
        '{1'b0, 16'd1,      16'd0,  16'd0,      16'd0,     1'b0, 1'b1},
        '{1'b0, 16'hFFF0,   16'd0,  16'h0018,   16'h0020,  1'b1, 1'b0},
        '{1'b0, 16'hFFFE,   16'd0,  16'hFFFF,   16'd0,     1'b1, 1'b0}
    };

    task automatic chk(input logic got, input logic exp, input string what);
        n_vec++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s got=%0b exp=%0b", what, got, exp);
        end
    endtask

    task automatic zero_counters();
        @(negedge clk);
        itb_mode = 1'b0;
        cam_en   = 1'b0;
        clim_in  = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    function automatic int tri_cnt(int k, int p);
        int m = k % (2 * p);
        return (m <= p) ? m : 2 * p - m;
    endfunction

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        rst = 1'b1; prim_count = 16'd5; sec_count = 16'd7; mtb_sel = 1'b0;
        itb_mode = 1'b0; cam_en = 1'b0; iue = 1'b0; xres_en = 1'b0; clim_in = 1'b0;
        duty_h = 16'd50; duty_l = 16'd0; phase_h = 16'd0; phase_l = 16'd0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk); #1;
        // R10: active duty cleared, so 5 < 0 is false
        chk(pwm_h, 1'b0, "R10 reset pwm_h");
        chk(pwm_l, 1'b1, "R10 reset pwm_l");
        // R8: shadow held without boundary
        @(negedge clk); #1;
        chk(pwm_h, 1'b0, "R8 shadow held");
        chk(cyc_strobe, 1'b0, "R9 no strobe at count 5");
        @(negedge clk);
        prim_count = 16'd0; #1;
        chk(cyc_strobe, 1'b1, "R9 strobe at master zero");
        @(negedge clk);
        prim_count = 16'd5; #1;
        chk(pwm_h, 1'b1, "R8 loaded at boundary");

        // table walk, shared mode
        iue = 1'b1;
        foreach (VECS[i]) begin
            @(negedge clk);
            mtb_sel = VECS[i].sel; prim_count = VECS[i].pc; sec_count = VECS[i].sc;
            duty_h = VECS[i].duty; phase_h = VECS[i].ph;
            duty_l = 16'd3; phase_l = 16'd9;
            @(negedge clk); #1;
            chk(pwm_h, VECS[i].eh, $sformatf("R1 R2 vec%0d pwm_h", i));
            chk(pwm_l, VECS[i].el, $sformatf("R1 vec%0d pwm_l", i));
        end

        // R6: center bit ignored in shared mode
        @(negedge clk);
        mtb_sel = 1'b0; prim_count = 16'd10; duty_h = 16'd20; phase_h = 16'd0;
        cam_en = 1'b1;
        @(negedge clk); #1;
        chk(pwm_h, 1'b1, "R6 cam ignored pwm_h");
        prim_count = 16'd25; #1;
        chk(pwm_h, 1'b0, "R6 cam ignored pwm_h high count");

        // R4: local edge-aligned
        @(negedge clk);
        cam_en = 1'b0; duty_h = 16'd2; phase_h = 16'd4; duty_l = 16'd3; phase_l = 16'd5;
        zero_counters();
        itb_mode = 1'b1;
        for (int k = 0; k < 12; k++) begin
            if (k > 0) @(negedge clk);
            #1;
            chk(pwm_h, (k % 5) < 2, $sformatf("R4 edge hi k%0d", k));
            chk(pwm_l, (k % 6) < 3, $sformatf("R4 edge lo k%0d", k));
            chk(cyc_strobe, (k % 5) == 4, $sformatf("R9 edge strobe k%0d", k));
        end

        // R5: local center-aligned, low duty above period (R3)
        duty_h = 16'd2; phase_h = 16'd3; duty_l = 16'd9; phase_l = 16'd4;
        zero_counters();
        itb_mode = 1'b1; cam_en = 1'b1;
        for (int k = 0; k < 14; k++) begin
            if (k > 0) @(negedge clk);
            #1;
            chk(pwm_h, tri_cnt(k, 3) < 2, $sformatf("R5 center hi k%0d", k));
            chk(pwm_l, 1'b1, $sformatf("R3 duty above period k%0d", k));
            chk(cyc_strobe, tri_cnt(k, 3) == 0, $sformatf("R9 center strobe k%0d", k));
        end

        // R7: current-limit clear of high counter only
        duty_h = 16'd3; phase_h = 16'd9; duty_l = 16'd8; phase_l = 16'd9;
        xres_en = 1'b1;
        zero_counters();
        itb_mode = 1'b1;
        for (int k = 0; k < 11; k++) begin
            if (k > 0) @(negedge clk);
            if (k == 7) clim_in = 1'b0;
            #1;
            if (k == 6) begin
                chk(pwm_h, 1'b0, "R7 before clear");
                clim_in = 1'b1;
            end
            if (k == 7) begin
                chk(pwm_h, 1'b1, "R7 high cleared");
                chk(pwm_l, 1'b1, "R7 low count 7");
            end
            if (k == 9) chk(pwm_l, 1'b0, "R7 low not cleared");
            if (k == 10) chk(pwm_h, 1'b0, "R7 high count 3");
        end

        // R7: clim ignored when xres_en=0
        xres_en = 1'b0;
        zero_counters();
        itb_mode = 1'b1;
        for (int k = 0; k < 8; k++) begin
            if (k > 0) @(negedge clk);
            if (k == 7) clim_in = 1'b0;
            #1;
            if (k == 6) clim_in = 1'b1;
            if (k == 7) chk(pwm_h, 1'b0, "R7 clim ignored");
        end

        // R8: shadowed duty change in local edge mode
        duty_h = 16'd1; phase_h = 16'd4; duty_l = 16'd0; phase_l = 16'd5;
        zero_counters();
        iue = 1'b0;
        itb_mode = 1'b1;
        for (int k = 0; k < 9; k++) begin
            if (k > 0) @(negedge clk);
            #1;
            if (k == 1) duty_h = 16'd4;
            if (k == 2) chk(pwm_h, 1'b0, "R8 old duty held k2");
            if (k == 4) chk(pwm_h, 1'b0, "R8 old duty at boundary");
            if (k == 5) chk(pwm_h, 1'b1, "R8 new duty after wrap");
            if (k == 8) chk(pwm_h, 1'b1, "R8 new duty count 3");
            if (k == 3) chk(pwm_l, 1'b0, "R3 zero duty low");
        end

        finish_run();
    end

endmodule